// File: doc/BRIEF.md
# Programmable Single-Bit Crossbar Switch

This block connects N single-bit input lines to N single-bit output lines through a square matrix of configuration bits. The matrix holds one bit per crosspoint and is arranged as one column per output. An output line is high when any input whose crosspoint bit is set in that output's column is high. The path from the inputs to the outputs has no registers. Any input may feed any output, and a single input may feed several outputs or all of them at once.

Configuration uses the data inputs themselves as write data. Software holds the required input lines high and pulses the write strobe of one or more output columns. On the clock edge, the values on the inputs are ORed into each strobed column. A one-cycle clear command empties the whole matrix. A one-cycle preset command replaces the matrix with one of two built-in maps: broadcast, where input 0 feeds every output, or corner turn, where input i feeds output N-1-i.

Each cycle, a priority decoder turns the command inputs into a single operation. The operations are HOLD, WRITE, PRESET_BCAST, PRESET_CTURN and CLEAR. The decoder has no stored state. The matrix register moves from its current contents to a new configuration according to the operation chosen. The transitions are:
- HOLD keeps every column.
- WRITE ORs the inputs into the strobed columns.
- PRESET_BCAST loads the broadcast map.
- PRESET_CTURN loads the corner-turn map.
- CLEAR loads all zeros.

Top module: `bit_crossbar`

## Requirements
- R1: Output bit j equals the OR, over all rows i, of (crosspoint bit [j][i] AND input bit i), in the same cycle with no clock delay.
- R2: When wr_en[j] is high at a clock edge (no clear or preset), column j becomes its old value ORed with din. A write never clears a bit that is already set.
- R3: Several wr_en bits may be high in one cycle; every strobed column receives the same din, so one input can drive several outputs.
- R4: clr high at a clock edge sets every crosspoint bit to 0; afterwards dout is 0 for any din.
- R5: preset high with preset_sel = 0 replaces the whole matrix with the broadcast map: every output follows din[0].
- R6: preset high with preset_sel = 1 replaces the whole matrix with the corner-turn map: dout[j] follows din[N-1-j].
- R7: Priority within one cycle is clr over preset over wr_en; a lower-priority request in the same cycle has no effect.
- R8: A column whose wr_en bit is low, in a cycle with no clr or preset, keeps its configuration.
- R9: rst_n low (asynchronous) clears the matrix, so dout is 0 for any din.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, clears the matrix |
| clr | input | 1 | Synchronous one-cycle clear of all crosspoints |
| preset | input | 1 | Load a built-in map this cycle |
| preset_sel | input | 1 | Selects the map: 0 = broadcast from input 0, 1 = corner turn |
| wr_en | input | N | Per-output column write strobes |
| din | input | N | Data inputs, also used as the column write data |
| dout | output | N | Switched outputs |

## Verification
The bench goes after the cases where operations collide:
- Clear, preset and writes arriving in the same cycle. A design with the priority reversed would leave stray crosspoints after a clear, or would merge written bits into a preset map.
- A column rewritten without a clear. This must accumulate bits, so a design that overwrote the column instead of ORing would lose earlier connections.
- Multi-column strobes, which must fan one input out to several outputs.
- Unstrobed columns, which must stay put.
- The corner-turn preset, which exposes an index reversed the wrong way as swapped outputs.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_WRITE,
        OP_PRESET_BCAST,
        OP_PRESET_CTURN,
        OP_CLEAR
    } xbar_op_e;

endpackage

// File: rtl/xbar_op_decode.sv
module xbar_op_decode
    import xbar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clr,
    input  logic         preset,
    input  logic         preset_sel,
    input  logic [N-1:0] wr_en,
    output xbar_op_e     op
);

    // Priority: clear, then preset, then column writes.
    always_comb begin
        if (clr)
            op = OP_CLEAR;
        else if (preset)
            op = preset_sel ? OP_PRESET_CTURN : OP_PRESET_BCAST;
        else if (|wr_en)
            op = OP_WRITE;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/xbar_cell_array.sv
module xbar_cell_array
    import xbar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  xbar_op_e              op,
    input  logic [N-1:0]          wr_en,
    input  logic [N-1:0]          din,
    output logic [N-1:0][N-1:0]   cfg
);

    generate
        for (genvar j = 0; j < N; j++) begin : g_col
            localparam logic [N-1:0] BCAST_COL = N'(1);
            localparam logic [N-1:0] CTURN_COL = N'(1) << (N - 1 - j);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg[j] <= '0;
                end else begin
                    unique case (op)
                        OP_CLEAR:        cfg[j] <= '0;
                        OP_PRESET_BCAST: cfg[j] <= BCAST_COL;
                        OP_PRESET_CTURN: cfg[j] <= CTURN_COL;
                        OP_WRITE:        if (wr_en[j]) cfg[j] <= cfg[j] | din;
                        OP_HOLD:         cfg[j] <= cfg[j];
                        default:         cfg[j] <= cfg[j];
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/xbar_or_tree.sv
module xbar_or_tree #(
    parameter int N = 8
) (
    input  logic [N-1:0][N-1:0] cfg,
    input  logic [N-1:0]        din,
    output logic [N-1:0]        dout
);

    generate
        for (genvar j = 0; j < N; j++) begin : g_out
            logic [N-1:0] gated;
            assign gated   = cfg[j] & din;
            assign dout[j] = |gated;
        end
    endgenerate

endmodule

// File: rtl/bit_crossbar.sv
module bit_crossbar
    import xbar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         preset,
    input  logic         preset_sel,
    input  logic [N-1:0] wr_en,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    xbar_op_e             op;
    logic [N-1:0][N-1:0]  cfg;

    xbar_op_decode #(.N(N)) u_decode (
        .clr        (clr),
        .preset     (preset),
        .preset_sel (preset_sel),
        .wr_en      (wr_en),
        .op         (op)
    );

    xbar_cell_array #(.N(N)) u_cells (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .wr_en (wr_en),
        .din   (din),
        .cfg   (cfg)
    );

    xbar_or_tree #(.N(N)) u_tree (
        .cfg  (cfg),
        .din  (din),
        .dout (dout)
    );

endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         preset,
    input logic         preset_sel,
    input logic [N-1:0] wr_en,
    input logic [N-1:0] din,
    input logic [N-1:0] dout
);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dout == '0));

    // R5 and R7: preset wins over writes
    assert_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && !clr && !preset_sel) |=> (dout == {N{din[0]}}));

    generate
        for (genvar j = 0; j < N; j++) begin : g_chk
            // R6 and R7
            assert_cturn_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (preset && !clr && preset_sel) |=> (dout[j] == din[N-1-j]));

            assert_write_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && !preset && wr_en[j] && (|din)) |=> ($stable(din) -> dout[j]));

            assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && !preset && !wr_en[j]) |=> ($stable(din) -> $stable(dout[j])));
        end
    endgenerate

endmodule

bind bit_crossbar xbar_checker #(.N(N)) u_xbar_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .preset     (preset),
    .preset_sel (preset_sel),
    .wr_en      (wr_en),
    .din        (din),
    .dout       (dout)
);

// File: tb/test_bit_crossbar.sv
`timescale 1ns/1ps
module test_bit_crossbar;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         preset = 1'b0;
    logic         preset_sel = 1'b0;
    logic [N-1:0] wr_en = '0;
    logic [N-1:0] din = '0;
    logic [N-1:0] dout;

    logic [N-1:0] model [N];
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bit_crossbar #(.N(N)) i_bit_crossbar (
        .clk(clk), .rst_n(rst_n), .clr(clr), .preset(preset),
        .preset_sel(preset_sel), .wr_en(wr_en), .din(din), .dout(dout)
    );

    function automatic logic [N-1:0] expect_out(input logic [N-1:0] d);
        logic [N-1:0] r;
        for (int j = 0; j < N; j++) r[j] = |(model[j] & d);
        return r;
    endfunction

    task automatic model_clear();
        for (int j = 0; j < N; j++) model[j] = '0;
    endtask

    // Model update following the priority rule (R7)
    task automatic model_step(input logic c, input logic p, input logic s,
                              input logic [N-1:0] w, input logic [N-1:0] d);
        for (int j = 0; j < N; j++) begin
            if (c)           model[j] = '0;
            else if (p && !s) model[j] = N'(1);
            else if (p)      model[j] = N'(1) << (N - 1 - j);
            else if (w[j])   model[j] = model[j] | d;
        end
    endtask

    task automatic check(input string tag, input logic [N-1:0] exp_v);
        checks++;
        if (dout !== exp_v) begin
            failures++;
            $display("FAIL %s dout=%b expected=%b", tag, dout, exp_v);
        end
    endtask

    task automatic apply(input logic c, input logic p, input logic s,
                         input logic [N-1:0] w, input logic [N-1:0] d);
        @(negedge clk);
        clr = c; preset = p; preset_sel = s; wr_en = w; din = d;
        @(posedge clk);
        model_step(c, p, s, w, d);
        @(negedge clk);
        clr = 1'b0; preset = 1'b0; wr_en = '0;
    endtask

    task automatic probe(input string tag, input int count);
        for (int k = 0; k < count; k++) begin
            din = N'($urandom);
            #1;
            check(tag, expect_out(din));
            #0.5;
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        // R9: asynchronous reset state
        din = '1;
        #1 check("R9 reset", '0);
        #5 rst_n = 1'b1;
        @(negedge clk);
        probe("R9 after reset", 4);

        // R2: single connection, then accumulate without clear
        apply(0, 0, 0, 8'b0000_0100, 8'b0000_1000);
        probe("R2 write", 4);
        apply(0, 0, 0, 8'b0000_0100, 8'b0100_0000);
        @(negedge clk); din = 8'b0100_0000; #1;
        check("R2 accumulate", 8'b0000_0100);

        // R3: fan one input to several outputs in one write
        apply(0, 0, 0, 8'b1010_0001, 8'b0000_0010);
        @(negedge clk); din = 8'b0000_0010; #1;
        check("R3 multi-column", 8'b1010_0001);
        probe("R3 multi-column", 4);

        // R1: per-column OR across rows
        probe("R1 or-of-and", 8);

        // R8: unstrobed columns unchanged
        apply(0, 0, 0, 8'b0000_0000, 8'b1111_1111);
        probe("R8 hold", 4);

        // R4: clear
        apply(1, 0, 0, '0, '0);
        @(negedge clk); din = '1; #1;
        check("R4 clear", '0);

        // R5, R6: presets
        apply(0, 1, 0, '0, '0);
        @(negedge clk); din = 8'b0000_0001; #1;
        check("R5 broadcast", 8'hFF);
        probe("R5 broadcast", 4);
        apply(0, 1, 1, '0, '0);
        @(negedge clk); din = 8'b0000_0011; #1;
        check("R6 corner turn", 8'b1100_0000);
        probe("R6 corner turn", 4);

        // R7: priority collisions
        apply(0, 1, 1, 8'hFF, 8'hFF);
        @(negedge clk); din = 8'b0000_0001; #1;
        check("R7 preset over write", 8'b1000_0000);
        apply(1, 1, 0, 8'hFF, 8'hFF);
        @(negedge clk); din = 8'hFF; #1;
        check("R7 clear over preset", '0);

        // Random mix, all requirements against the model
        for (int it = 0; it < 400; it++) begin
            int kind;
            kind = $urandom_range(0, 19);
            if (kind == 0)
                apply(1, $urandom_range(0, 1), $urandom_range(0, 1), N'($urandom), N'($urandom));
            else if (kind < 3)
                apply(0, 1, $urandom_range(0, 1), N'($urandom), N'($urandom));
            else
                apply(0, 0, 0, N'($urandom), N'(1) << $urandom_range(0, N - 1));
            probe("R1 R2 R7 random", 3);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule